// File: doc/BRIEF.md
# Burst Data Buffer with Short-Burst Release

This block sits between a host that moves data one byte per access and the card-side data engine of a memory-card controller. Each direction has its own store made of two 32-byte halves. One half fills while the other drains, and the block asks the host for service one whole burst at a time. On the transmit side, a request tells the host that a full 32-byte half is empty and can be filled. On the receive side, a request tells the host that a half is complete and can be read out.

A transfer is set up at start time with a block length of 1 to 2048 bytes and a block count. The block counts the bytes that cross the engine side. After the final byte it closes the transfer with a one-cycle completion pulse. An engine-reported data error ends the transfer with its own pulse and suppresses completion. If the last host fill of a transmit transfer is shorter than a burst, the host releases it with a flush strobe, so no padding is needed. On a receive transfer, the last bytes are released to the host automatically. A programmable idle bound raises a sticky status flag when the card delivers no read data for too long.

Top module: `blkdata_fifo`

## Requirements
- R1: After reset, busy, tx_req, rx_req, done_evt, err_evt, rd_tmo_flag and eng_tx_valid are all low.
- R2: On a transmit transfer (cfg_dir_tx=1), bytes written by the host leave on eng_tx_data in write order. tx_req is high while the half being filled is completely empty and the host still owes bytes to the transfer.
- R3: The transmit store holds two 32-byte halves. After 32 writes, tx_req stays high because the second half is free. After 64 writes with no draining, tx_req is low and further host writes are dropped until a half drains.
- R4: host_flush seals a partly filled transmit half so the engine receives exactly the bytes written. A flush while the current half holds no bytes has no effect: eng_tx_valid stays low.
- R5: On a receive transfer (cfg_dir_tx=0), engine bytes are grouped into 32-byte halves. rx_req rises once a half is complete, and host reads return the bytes in arrival order.
- R6: The last engine byte of a receive transfer seals its half even when the half holds fewer than 32 bytes. rx_req stays high until those bytes are read and then falls.
- R7: A transfer moves cfg_blk_len × cfg_blk_cnt bytes on the engine side. One cycle after the final engine byte, done_evt is high for exactly one cycle and busy is low.
- R8: eng_data_err during a transfer gives a one-cycle err_evt in the next cycle and ends the transfer. done_evt stays low, even if the error coincides with the final byte.
- R9: On a receive transfer with a nonzero bound L, rd_tmo_flag rises after L consecutive cycles in which the block can accept a byte but none arrives. An accepted byte restarts the count. The flag stays high until the next accepted start.
- R10: A start with a block length of 0 or above 2048, or a block count of 0, is ignored: busy stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_start | input | 1 | Start a transfer (taken only while idle) |
| cfg_dir_tx | input | 1 | 1 = transmit to card, 0 = receive from card |
| cfg_blk_len | input | 12 | Bytes per block, 1..2048 |
| cfg_blk_cnt | input | 16 | Number of blocks |
| cfg_rd_tmo | input | 16 | Receive idle bound in cycles, 0 disables |
| host_tx_wr | input | 1 | Host writes one transmit byte |
| host_tx_data | input | 8 | Transmit byte |
| host_flush | input | 1 | Release a partly filled transmit half |
| host_rx_rd | input | 1 | Host reads one receive byte |
| host_rx_data | output | 8 | Receive byte at the head of the store |
| eng_tx_valid | output | 1 | Transmit byte available to the engine |
| eng_tx_data | output | 8 | Transmit byte to the engine |
| eng_tx_ready | input | 1 | Engine takes the transmit byte |
| eng_rx_valid | input | 1 | Engine offers a receive byte |
| eng_rx_data | input | 8 | Receive byte from the engine |
| eng_rx_ready | output | 1 | Block can accept a receive byte |
| eng_data_err | input | 1 | Engine reports a data error |
| tx_req | output | 1 | Host may write a full 32-byte burst |
| rx_req | output | 1 | A receive half is ready for the host |
| busy | output | 1 | Transfer in progress |
| done_evt | output | 1 | One-cycle completion pulse |
| err_evt | output | 1 | One-cycle data-error pulse |
| rd_tmo_flag | output | 1 | Sticky receive-timeout status |

## Verification
tx_req, rx_req, eng_tx_valid and eng_rx_ready are decoded from registers, so they reflect a push, pop, seal or start in the cycle after the edge that accepted it. The bench inspects them 1 ns after that rising edge. done_evt and err_evt are registered one edge after the final beat or the error, and they are checked at the first falling edge after that beat's handshake edge. rd_tmo_flag is set on the L-th idle edge after the last accepted byte. The bench counts edges from its own stimulus and checks one cycle before and one cycle after that edge. Byte order is compared against queues at falling edges, where every handshake input is stable.

// File: rtl/dfifo_pkg.sv
package dfifo_pkg;
   typedef enum logic {XF_RX = 1'b0, XF_TX = 1'b1} xfer_dir_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/dfifo_pingpong.sv
module dfifo_pingpong #(
   parameter int DW   = 8,
   parameter int HALF = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic [DW-1:0] push_data,
   input  logic          push_last,
   input  logic          seal,
   output logic          in_room,
   output logic          in_free,
   output logic          out_valid,
   output logic [DW-1:0] out_data,
   input  logic          pop
);
   localparam int PW = $clog2(HALF);
   localparam int CW = PW + 1;

   logic [1:0][CW-1:0] cnt_v;
   logic [1:0]         shut_v;
   logic [1:0]         close_v;
   logic [1:0]         free_v;
   logic               wsel, rsel;
   logic [PW-1:0]      rptr;
   logic [DW-1:0]      mem [2][HALF];

   generate
      for (genvar h = 0; h < 2; h++) begin : g_half
         logic [CW-1:0] cnt_r;
         logic          shut_r;
         logic          wr_act, seal_act;

         assign wr_act   = (wsel == h[0]) && push && !shut_r;
         assign seal_act = (wsel == h[0]) && !push && seal && !shut_r && (cnt_r != '0);
         assign close_v[h] = (wr_act && ((cnt_r == CW'(HALF - 1)) || push_last || seal)) || seal_act;
         assign free_v[h]  = (rsel == h[0]) && pop && shut_r && (CW'(rptr) == cnt_r - CW'(1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_r  <= '0;
               shut_r <= 1'b0;
            end else if (clr) begin
               cnt_r  <= '0;
               shut_r <= 1'b0;
            end else begin
               if (free_v[h]) begin
                  cnt_r  <= '0;
                  shut_r <= 1'b0;
               end else begin
                  if (wr_act)     cnt_r  <= cnt_r + CW'(1);
                  if (close_v[h]) shut_r <= 1'b1;
               end
            end
         end

         assign cnt_v[h]  = cnt_r;
         assign shut_v[h] = shut_r;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wsel <= 1'b0;
         rsel <= 1'b0;
         rptr <= '0;
      end else if (clr) begin
         wsel <= 1'b0;
         rsel <= 1'b0;
         rptr <= '0;
      end else begin
         if (|close_v) wsel <= ~wsel;
         if (|free_v) begin
            rsel <= ~rsel;
            rptr <= '0;
         end else if (pop && shut_v[rsel]) begin
            rptr <= rptr + PW'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (push && !shut_v[wsel]) mem[wsel][cnt_v[wsel][PW-1:0]] <= push_data;
   end

   assign in_room   = !shut_v[wsel];
   assign in_free   = !shut_v[wsel] && (cnt_v[wsel] == '0);
   assign out_valid = shut_v[rsel];
   assign out_data  = mem[rsel][rptr];

   AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> out_valid); // R2
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_v[0] <= CW'(HALF)) && (cnt_v[1] <= CW'(HALF))); // R3
   AST_EMPTY_SEAL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (seal && !push && !pop && !clr && (cnt_v[wsel] == '0)) |=> (shut_v == $past(shut_v))); // R4
endmodule

// File: rtl/dfifo_xfer_seq.sv
module dfifo_xfer_seq import dfifo_pkg::*; #(
   parameter int LEN_W       = 12,
   parameter int CNT_W       = 16,
   parameter int MAX_BLK_LEN = 2048
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             dir_tx_in,
   input  logic [LEN_W-1:0] blk_len,
   input  logic [CNT_W-1:0] blk_cnt,
   input  logic             beat,
   input  logic             host_acc,
   input  logic             data_err,
   output logic             start_ok,
   output logic             busy,
   output xfer_dir_e        dir,
   output logic             last_beat,
   output logic             owed,
   output logic             done_evt,
   output logic             err_evt
);
   localparam int TOT_W = LEN_W + CNT_W;

   logic [LEN_W-1:0] len_q, pos_q;
   logic [CNT_W-1:0] blk_q;
   logic [TOT_W-1:0] owe_q;

   assign start_ok  = start && !busy && (blk_len != '0) &&
                      (blk_len <= LEN_W'(MAX_BLK_LEN)) && (blk_cnt != '0);
   assign last_beat = busy && (pos_q == len_q - LEN_W'(1)) && (blk_q == CNT_W'(1));
   assign owed      = (owe_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         dir      <= XF_RX;
         len_q    <= '0;
         pos_q    <= '0;
         blk_q    <= '0;
         owe_q    <= '0;
         done_evt <= 1'b0;
         err_evt  <= 1'b0;
      end else begin
         done_evt <= 1'b0;
         err_evt  <= 1'b0;
         if (start_ok) begin
            busy  <= 1'b1;
            dir   <= dir_tx_in ? XF_TX : XF_RX;
            len_q <= blk_len;
            pos_q <= '0;
            blk_q <= blk_cnt;
            owe_q <= TOT_W'(blk_len) * TOT_W'(blk_cnt);
         end else if (busy) begin
            if (data_err) begin
               busy    <= 1'b0;
               err_evt <= 1'b1;
            end else if (beat && last_beat) begin
               busy     <= 1'b0;
               done_evt <= 1'b1;
            end
            if (beat) begin
               if (pos_q == len_q - LEN_W'(1)) begin
                  pos_q <= '0;
                  blk_q <= blk_q - CNT_W'(1);
               end else begin
                  pos_q <= pos_q + LEN_W'(1);
               end
            end
            if (host_acc) owe_q <= owe_q - TOT_W'(1);
         end
      end
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_evt |=> !done_evt); // R7
   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done_evt |-> (!busy && $past(busy))); // R7
   AST_ERR_BLOCKS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      err_evt |-> !done_evt); // R8
   AST_BAD_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && (blk_len == '0 || blk_cnt == '0)) |=> !busy); // R10
endmodule

// File: rtl/dfifo_rd_timer.sv
module dfifo_rd_timer #(
   parameter int TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [TMO_W-1:0] limit,
   input  logic             en,
   input  logic             idle,
   input  logic             hit,
   output logic             flag
);
   logic [TMO_W-1:0] lim_q, cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lim_q <= '0;
         cnt_q <= '0;
         flag  <= 1'b0;
      end else if (load) begin
         lim_q <= limit;
         cnt_q <= '0;
         flag  <= 1'b0;
      end else if (!en || hit) begin
         cnt_q <= '0;
      end else if (idle && (lim_q != '0) && !flag) begin
         if (cnt_q == lim_q - TMO_W'(1)) flag <= 1'b1;
         cnt_q <= cnt_q + TMO_W'(1);
      end
   end

   AST_TMO_RX_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(en && idle)); // R9
endmodule

// File: rtl/blkdata_fifo.sv
module blkdata_fifo import dfifo_pkg::*; #(
   parameter int DW          = 8,
   parameter int HALF        = 32,
   parameter int LEN_W       = 12,
   parameter int CNT_W       = 16,
   parameter int TMO_W       = 16,
   parameter int MAX_BLK_LEN = 2048
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_start,
   input  logic             cfg_dir_tx,
   input  logic [LEN_W-1:0] cfg_blk_len,
   input  logic [CNT_W-1:0] cfg_blk_cnt,
   input  logic [TMO_W-1:0] cfg_rd_tmo,
   input  logic             host_tx_wr,
   input  logic [DW-1:0]    host_tx_data,
   input  logic             host_flush,
   input  logic             host_rx_rd,
   output logic [DW-1:0]    host_rx_data,
   output logic             eng_tx_valid,
   output logic [DW-1:0]    eng_tx_data,
   input  logic             eng_tx_ready,
   input  logic             eng_rx_valid,
   input  logic [DW-1:0]    eng_rx_data,
   output logic             eng_rx_ready,
   input  logic             eng_data_err,
   output logic             tx_req,
   output logic             rx_req,
   output logic             busy,
   output logic             done_evt,
   output logic             err_evt,
   output logic             rd_tmo_flag
);
   generate
      if (!is_pow2(HALF) || HALF < 2) begin : g_bad_half
         $error("HALF must be a power of two of at least 2");
      end
      if (MAX_BLK_LEN >= (1 << LEN_W)) begin : g_bad_len
         $error("LEN_W too narrow for MAX_BLK_LEN");
      end
   endgenerate

   xfer_dir_e dir;
   logic      start_ok, last_beat, owed, is_tx, is_rx;
   logic      tx_room, tx_free, tx_ov;
   logic      rx_room, rx_free, rx_ov;
   logic      tx_push, tx_pop, rx_push, rx_pop, beat, host_acc;

   assign is_tx    = busy && (dir == XF_TX);
   assign is_rx    = busy && (dir == XF_RX);
   assign tx_push  = is_tx && host_tx_wr && owed;
   assign host_acc = tx_push && tx_room;
   assign eng_tx_valid = is_tx && tx_ov;
   assign tx_pop   = eng_tx_valid && eng_tx_ready;
   assign eng_rx_ready = is_rx && rx_room;
   assign rx_push  = eng_rx_valid && eng_rx_ready;
   assign rx_pop   = host_rx_rd && rx_ov;
   assign beat     = tx_pop || rx_push;
   assign tx_req   = is_tx && tx_free && owed;
   assign rx_req   = rx_ov;

   dfifo_xfer_seq #(.LEN_W(LEN_W), .CNT_W(CNT_W), .MAX_BLK_LEN(MAX_BLK_LEN)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(cfg_start), .dir_tx_in(cfg_dir_tx),
      .blk_len(cfg_blk_len), .blk_cnt(cfg_blk_cnt), .beat(beat), .host_acc(host_acc),
      .data_err(eng_data_err), .start_ok(start_ok), .busy(busy), .dir(dir),
      .last_beat(last_beat), .owed(owed), .done_evt(done_evt), .err_evt(err_evt));

   dfifo_pingpong #(.DW(DW), .HALF(HALF)) u_txbuf (
      .clk(clk), .rst_n(rst_n), .clr(start_ok), .push(tx_push), .push_data(host_tx_data),
      .push_last(1'b0), .seal(is_tx && host_flush), .in_room(tx_room), .in_free(tx_free),
      .out_valid(tx_ov), .out_data(eng_tx_data), .pop(tx_pop));

   dfifo_pingpong #(.DW(DW), .HALF(HALF)) u_rxbuf (
      .clk(clk), .rst_n(rst_n), .clr(start_ok), .push(rx_push), .push_data(eng_rx_data),
      .push_last(last_beat), .seal(1'b0), .in_room(rx_room), .in_free(rx_free),
      .out_valid(rx_ov), .out_data(host_rx_data), .pop(rx_pop));

   dfifo_rd_timer #(.TMO_W(TMO_W)) u_tmo (
      .clk(clk), .rst_n(rst_n), .load(start_ok), .limit(cfg_rd_tmo), .en(is_rx),
      .idle(eng_rx_ready && !eng_rx_valid), .hit(rx_push), .flag(rd_tmo_flag));

   AST_DIR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(eng_tx_valid && eng_rx_ready)); // R2
   AST_RXREQ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_req && !host_rx_rd && !start_ok) |=> rx_req); // R6
   AST_ERR_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && eng_data_err && !start_ok) |=> (err_evt && !busy)); // R8
endmodule

// File: tb/sim_blkdata_fifo.sv
module sim_blkdata_fifo;
   logic        clk = 1'b0, rst_n = 1'b0;
   logic        cfg_start = 0, cfg_dir_tx = 0;
   logic [11:0] cfg_blk_len = 0;
   logic [15:0] cfg_blk_cnt = 0, cfg_rd_tmo = 0;
   logic        host_tx_wr = 0, host_flush = 0, host_rx_rd = 0;
   logic [7:0]  host_tx_data = 0, host_rx_data, eng_tx_data, eng_rx_data = 0;
   logic        eng_tx_valid, eng_tx_ready = 0, eng_rx_valid = 0, eng_rx_ready, eng_data_err = 0;
   logic        tx_req, rx_req, busy, done_evt, err_evt, rd_tmo_flag;

   int n_chk = 0, n_fail = 0, beats = 0, exp_total = -1, done_cnt = 0;
   bit arm_done = 0, finished = 0;
   logic [7:0] txq[$], rxq[$];

   always #2 clk = ~clk;

   blkdata_fifo u0 (.*);

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic step(); @(posedge clk); #1; endtask

   task automatic do_start(input bit tx, input int len, input int cnt, input int tmo, input int tot);
      cfg_start = 1; cfg_dir_tx = tx; cfg_blk_len = 12'(len); cfg_blk_cnt = 16'(cnt);
      cfg_rd_tmo = 16'(tmo); beats = 0; exp_total = tot;
      step(); cfg_start = 0;
   endtask

   task automatic host_write(input logic [7:0] d, input bit expect_taken);
      host_tx_wr = 1; host_tx_data = d;
      if (expect_taken) txq.push_back(d);
      step(); host_tx_wr = 0;
   endtask

   task automatic flush(); host_flush = 1; step(); host_flush = 0; endtask

   task automatic rx_send(input logic [7:0] d);
      eng_rx_valid = 1; eng_rx_data = d;
      while (!eng_rx_ready) step();
      rxq.push_back(d);
      step(); eng_rx_valid = 0;
   endtask

   task automatic host_read(); host_rx_rd = 1; step(); host_rx_rd = 0; endtask

   task automatic wait_idle();
      for (int i = 0; i < 400 && busy; i++) step();
   endtask

   // monitor: scoreboard compares and completion timing
   always @(negedge clk) begin
      if (rst_n) begin
         if (arm_done) begin
            chk(done_evt && !busy, "R7 done pulse after final beat", done_evt, 1);
            arm_done = 0;
         end
         if (done_evt) done_cnt++;
         if (eng_tx_valid && eng_tx_ready) begin
            beats++;
            if (txq.size() == 0) chk(0, "R2 unexpected tx byte", eng_tx_data, -1);
            else begin
               logic [7:0] e;
               e = txq.pop_front();
               chk(eng_tx_data == e, "R2 tx byte order", eng_tx_data, e);
            end
            if (beats == exp_total) arm_done = 1;
         end
         if (eng_rx_valid && eng_rx_ready) begin
            beats++;
            if (beats == exp_total) arm_done = 1;
         end
         if (host_rx_rd && rx_req) begin
            if (rxq.size() == 0) chk(0, "R5 unexpected rx byte", host_rx_data, -1);
            else begin
               logic [7:0] e;
               e = rxq.pop_front();
               chk(host_rx_data == e, "R5 rx byte order", host_rx_data, e);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      finish_run();
   end

   initial begin
      repeat (3) step();
      rst_n = 1;
      step();
      chk({busy, tx_req, rx_req, done_evt, err_evt, rd_tmo_flag, eng_tx_valid} == 7'b0,
          "R1 reset state", {busy, tx_req, rx_req, done_evt, err_evt, rd_tmo_flag, eng_tx_valid}, 0);

      // R10: illegal starts
      do_start(1, 0, 1, 0, -1);
      chk(!busy, "R10 zero length ignored", busy, 0);
      do_start(1, 2049, 1, 0, -1);
      chk(!busy, "R10 oversize length ignored", busy, 0);
      do_start(1, 4, 0, 0, -1);
      chk(!busy, "R10 zero count ignored", busy, 0);

      // transmit: 2 blocks of 40 bytes
      do_start(1, 40, 2, 0, 80);
      chk(tx_req, "R2 tx_req on empty half", tx_req, 1);
      flush();
      chk(!eng_tx_valid && tx_req, "R4 flush on empty half ignored", eng_tx_valid, 0);
      for (int i = 0; i < 32; i++) host_write(8'(i + 16), 1);
      chk(tx_req, "R3 second half free", tx_req, 1);
      chk(eng_tx_valid, "R2 full half offered", eng_tx_valid, 1);
      for (int i = 32; i < 64; i++) host_write(8'(i + 16), 1);
      chk(!tx_req, "R3 both halves full", tx_req, 0);
      host_write(8'hEE, 0);
      eng_tx_ready = 1;
      repeat (33) step();
      chk(tx_req, "R3 drained half requested again", tx_req, 1);
      for (int i = 64; i < 80; i++) host_write(8'(i + 16), 1);
      chk(!tx_req, "R2 no request once host owes nothing", tx_req, 0);
      flush();
      wait_idle();
      step();
      eng_tx_ready = 0;
      chk(txq.size() == 0 && beats == 80, "R7 tx byte total", beats, 80);
      chk(!done_evt, "R7 done one cycle only", done_evt, 0);

      // receive: 3 blocks of 20 bytes
      do_start(0, 20, 3, 0, 60);
      for (int i = 0; i < 32; i++) rx_send(8'(i * 3 + 1));
      chk(rx_req, "R5 rx_req on full half", rx_req, 1);
      for (int i = 32; i < 60; i++) rx_send(8'(i * 3 + 1));
      step();
      chk(!busy, "R7 rx transfer ended", busy, 0);
      for (int i = 0; i < 32; i++) host_read();
      chk(rx_req, "R6 short final half ready", rx_req, 1);
      for (int i = 0; i < 28; i++) host_read();
      chk(!rx_req && rxq.size() == 0, "R6 rx_req falls when emptied", rx_req, 0);

      // data error on the final beat
      do_start(1, 8, 1, 0, -1);
      for (int i = 0; i < 8; i++) host_write(8'(200 + i), 1);
      flush();
      for (int i = 0; i < 8; i++) begin
         eng_tx_ready = 1;
         eng_data_err = (i == 7);
         step();
      end
      eng_tx_ready = 0; eng_data_err = 0;
      chk(err_evt, "R8 err_evt pulse", err_evt, 1);
      chk(!done_evt && !busy, "R8 done suppressed", done_evt, 0);
      step();
      chk(!err_evt && txq.size() == 0, "R8 err_evt one cycle", err_evt, 0);

      // read timeout, bound 6
      do_start(0, 4, 1, 6, 4);
      repeat (4) step();
      rx_send(8'hA1);
      repeat (5) step();
      chk(!rd_tmo_flag, "R9 no flag before bound", rd_tmo_flag, 0);
      step();
      chk(rd_tmo_flag, "R9 flag at bound", rd_tmo_flag, 1);
      rx_send(8'hA2); rx_send(8'hA3); rx_send(8'hA4);
      chk(rd_tmo_flag, "R9 flag sticky", rd_tmo_flag, 1);
      step();
      for (int i = 0; i < 4; i++) host_read();
      do_start(0, 1, 1, 0, 1);
      chk(!rd_tmo_flag, "R9 flag cleared by start", rd_tmo_flag, 0);
      rx_send(8'h5C);
      step();
      host_read();
      chk(rxq.size() == 0 && !rx_req, "R6 single byte released", rx_req, 0);

      chk(done_cnt == 4, "R7 completion count", done_cnt, 4);
      repeat (2) step();
      finish_run();
   end
endmodule